// File: doc/BRIEF.md
# NAND flash bus timing sequencer

This block turns single host requests into NAND flash bus cycles. A request names a cycle kind (command, address or data), a direction, a target bank and the write data. The sequencer drives the chip enables, the latch-enable pins (CLE for commands, ALE for addresses), the active-low write and read strobes, the data-bus output enable and the outgoing data. On reads it samples the incoming data and returns it with a one-cycle done pulse.

Every access runs through the same phases: setup, an optional read-after-latch gap, the strobe pulse, a stretch that follows the wait input, hold, and a one-cycle turnaround. The host programs each length on configuration inputs, and each length is counted in system clock cycles. The bus can be 8 or 16 bits wide. The chip enable of the last bank used stays asserted between accesses, so that multi-cycle flash command sequences keep the device selected.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, CLE=0, ALE=0, we_n=1, re_n=1, dq_oe=0, and only bank 0's enable is low (nand_ce_n=4'b1110).
- R2: A request is taken only while busy=0. busy stays high until the cycle after the one-cycle done pulse. A request raised during an access is dropped and starts no second access.
- R3: req_type 2'b00 (command) raises CLE, 2'b01 (address) raises ALE and 2'b10 (data) raises neither. The chosen line is high from the first setup cycle to the last hold cycle.
- R4: When no read gap applies, the strobe falls after exactly cfg_setup+1 cycles of setup.
- R5: The strobe is we_n when req_write=1 and re_n when req_write=0, never both. With nand_wait_n high it stays low for cfg_pulse+1 cycles.
- R6: If nand_wait_n is low in the last cycle of the pulse, the strobe stays low until the cycle after nand_wait_n is sampled high again.
- R7: After the strobe rises, the latch line and the write data are held for cfg_hold+1 cycles. Then done is high for one cycle, with CLE, ALE and dq_oe low and both strobes high.
- R8: A data read (type 2'b10, req_write=0) that directly follows a command access adds cfg_cle_gap+1 cycles before re_n falls. One that directly follows an address access adds cfg_ale_gap+1 cycles. One that follows a data access adds none.
- R9: On a write, dq_oe stays low for the first cfg_float cycles of the access (zero is allowed) and is then high until hold ends. dq_oe is never high on a read. nand_dq_out carries the write data.
- R10: Read data is sampled from nand_dq_in in the last strobe-low cycle. It appears on rdata in the done cycle and stays there until the next read.
- R11: req_bank (0..3) selects the enable nand_ce_n[req_bank], which goes low from acceptance and stays low after the access. Exactly one enable is low at any time.
- R12: With cfg_wide=0 the bus is 8 bits: nand_dq_out[15:8] is zero and rdata[15:8] is zero. With cfg_wide=1 all 16 bits pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_cle_gap | input | 4 | Read gap after a command access, n+1 cycles |
| cfg_ale_gap | input | 4 | Read gap after an address access, n+1 cycles |
| cfg_float | input | 8 | Write cycles with the bus undriven, n cycles |
| cfg_hold | input | 8 | Hold after the strobe, n+1 cycles |
| cfg_pulse | input | 8 | Strobe low time, n+1 cycles |
| cfg_setup | input | 8 | Setup before the strobe, n+1 cycles |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_type | input | 2 | 00 command, 01 address, 10 data |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Target bank |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 16 | Captured read data |
| nand_ce_n | output | 4 | Per-bank chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_out | output | 16 | Data bus outgoing value |
| nand_dq_in | input | 16 | Data bus incoming value |
| nand_wait_n | input | 1 | Device wait, active low |

## Verification
A request is driven on a falling edge and taken on the next rising edge. The first setup cycle shows at the falling edge after that, and each later phase follows after the number of cycles its own field gives. The bench does not predict absolute cycle numbers. It samples on every falling edge and sorts each sample by the ports' own state: before the strobe, strobe low, after the strobe, or done. It then compares the length of each phase with the expected n or n+1. Read data changes on every strobe cycle, so the value returned at done shows which cycle was sampled.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter int DW = 16,
  parameter int NB = 4,
  parameter int TW = 8,
  parameter int GW = 4,
  localparam int BW = $clog2(NB),
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic [GW-1:0] cfg_cle_gap,
  input  logic [GW-1:0] cfg_ale_gap,
  input  logic [TW-1:0] cfg_float,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_pulse,
  input  logic [TW-1:0] cfg_setup,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic          req_write,
  input  logic [BW-1:0] req_bank,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [NB-1:0] nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          nand_dq_oe,
  output logic [DW-1:0] nand_dq_out,
  input  logic [DW-1:0] nand_dq_in,
  input  logic          nand_wait_n
);

  localparam logic [1:0] K_CMD  = 2'b00;
  localparam logic [1:0] K_ADDR = 2'b01;
  localparam logic [1:0] K_DATA = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_GAP, S_PULSE, S_STRETCH, S_HOLD, S_TURN} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [TW-1:0] flt;
  logic [1:0]    kind, last_kind;
  logic          wr;
  logic [BW-1:0] bank;
  logic [DW-1:0] wdat;
  logic          gap_on;
  logic [GW-1:0] gap_len;
  logic [DW-1:0] rdat;

  wire active   = (st == S_SETUP) || (st == S_GAP) || (st == S_PULSE) ||
                  (st == S_STRETCH) || (st == S_HOLD);
  wire strobe   = (st == S_PULSE) || (st == S_STRETCH);
  wire take     = (st == S_IDLE) && req_valid;
  wire rd_data  = (req_type == K_DATA) && !req_write;
  wire [DW-1:0] cap = cfg_wide ? nand_dq_in : {{HW{1'b0}}, nand_dq_in[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      flt       <= '0;
      kind      <= K_DATA;
      last_kind <= K_DATA;
      wr        <= 1'b0;
      bank      <= '0;
      wdat      <= '0;
      gap_on    <= 1'b0;
      gap_len   <= '0;
      rdat      <= '0;
    end else begin
      if (take)
        flt <= cfg_float;
      else if (flt != '0)
        flt <= flt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          st        <= S_SETUP;
          cnt       <= cfg_setup;
          kind      <= req_type;
          last_kind <= req_type;
          wr        <= req_write;
          bank      <= req_bank;
          wdat      <= req_wdata;
          gap_on    <= rd_data && (last_kind == K_CMD || last_kind == K_ADDR);
          gap_len   <= (last_kind == K_CMD) ? cfg_cle_gap : cfg_ale_gap;
        end
        S_SETUP: if (cnt == '0) begin
          if (gap_on) begin
            st  <= S_GAP;
            cnt <= TW'(gap_len);
          end else begin
            st  <= S_PULSE;
            cnt <= cfg_pulse;
          end
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt == '0) begin
          st  <= S_PULSE;
          cnt <= cfg_pulse;
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == '0) begin
          if (!nand_wait_n) st <= S_STRETCH;
          else begin
            st   <= S_HOLD;
            cnt  <= cfg_hold;
            rdat <= wr ? rdat : cap;
          end
        end else cnt <= cnt - 1'b1;
        S_STRETCH: if (nand_wait_n) begin
          st   <= S_HOLD;
          cnt  <= cfg_hold;
          rdat <= wr ? rdat : cap;
        end
        S_HOLD: if (cnt == '0) st <= S_TURN;
                else cnt <= cnt - 1'b1;
        S_TURN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_TURN);
  assign rdata       = rdat;
  assign nand_ce_n   = ~(NB'(1) << bank);
  assign nand_cle    = active && (kind == K_CMD);
  assign nand_ale    = active && (kind == K_ADDR);
  assign nand_we_n   = !(strobe && wr);
  assign nand_re_n   = !(strobe && !wr);
  assign nand_dq_oe  = active && wr && (flt == '0);
  assign nand_dq_out = cfg_wide ? wdat : {{HW{1'b0}}, wdat[HW-1:0]};

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r11_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nand_ce_n) == 1);
  a_r11_enable_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(nand_ce_n));
  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  a_r7_turn_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!nand_cle && !nand_ale && !nand_dq_oe && nand_we_n && nand_re_n));
  a_r6_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !nand_wait_n && (st == S_STRETCH)) |=> strobe);

endmodule

// File: tb/test_nand_bus_seq.sv
`timescale 1ns/1ps
module test_nand_bus_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0;
  logic [3:0] cfg_cle_gap = 0, cfg_ale_gap = 0;
  logic [7:0] cfg_float = 0, cfg_hold = 0, cfg_pulse = 0, cfg_setup = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_type = 0, req_bank = 0;
  logic [15:0] req_wdata = 0, nand_dq_in = 0;
  logic nand_wait_n = 1;
  logic busy, done, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] rdata, nand_dq_out;
  logic [3:0] nand_ce_n;

  nand_bus_seq i_nand_bus_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int n_pre, n_stb, n_post, n_hiz;
  logic s_cle, s_ale, stb_we, stb_re, rd_oe, turn_ok, idle_after, timeout;
  logic [3:0] s_ce;
  logic [15:0] s_dq, got_rd;

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] ty, input logic wr, input logic [1:0] bk,
                        input logic [15:0] wd, input int rel, input int ghost_at,
                        input logic [15:0] rbase);
    logic oe_on;
    n_pre = 0; n_stb = 0; n_post = 0; n_hiz = 0; oe_on = 0;
    s_cle = 0; s_ale = 0; stb_we = 0; stb_re = 0; rd_oe = 0; turn_ok = 0; timeout = 1;
    s_ce = 0; s_dq = 0; got_rd = 0;
    @(negedge clk);
    req_valid = 1; req_type = ty; req_write = wr; req_bank = bk; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        got_rd  = rdata;
        turn_ok = !nand_cle && !nand_ale && !nand_dq_oe && nand_we_n && nand_re_n;
        timeout = 0;
        break;
      end
      if (!nand_we_n || !nand_re_n) begin
        n_stb++;
        s_cle = nand_cle; s_ale = nand_ale; s_ce = nand_ce_n; s_dq = nand_dq_out;
        if (!nand_we_n) stb_we = 1;
        if (!nand_re_n) stb_re = 1;
        if (!wr) nand_dq_in = rbase + 16'(n_stb);
        if (rel != 0 && n_stb == rel) nand_wait_n = 1;
      end else if (n_stb == 0) n_pre++;
      else n_post++;
      if (nand_dq_oe) oe_on = 1;
      else if (!oe_on) n_hiz++;
      if (nand_dq_oe && !wr) rd_oe = 1;
      if (ghost_at != 0 && n_stb == 0 && n_pre == ghost_at) begin
        req_valid = 1; req_bank = 2'd3;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    if (timeout) ck("R2 access never finished", 1, 0);
    @(negedge clk);
    idle_after = !busy && !done;
  endtask

  task automatic t_reset;
    ck("R1 busy", busy, 0);
    ck("R1 done", done, 0);
    ck("R1 cle/ale", {nand_cle, nand_ale}, 0);
    ck("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
    ck("R1 oe", nand_dq_oe, 0);
    ck("R1 ce_n", nand_ce_n, 4'b1110);
  endtask

  task automatic t_cmd_write;
    cfg_setup = 2; cfg_pulse = 1; cfg_hold = 0; cfg_float = 0;
    access(2'b00, 1, 0, 16'h0070, 0, 0, 0);
    ck("R4 setup length", n_pre, 3);
    ck("R5 pulse length", n_stb, 2);
    ck("R5 write uses we_n", {stb_we, stb_re}, 2'b10);
    ck("R7 hold length", n_post, 1);
    ck("R7 done cycle released", turn_ok, 1);
    ck("R3 command raises cle only", {s_cle, s_ale}, 2'b10);
    ck("R9 float zero drives at once", n_hiz, 0);
    ck("R9 data out", s_dq, 16'h0070);
    ck("R2 idle after done", idle_after, 1);
  endtask

  task automatic t_long_hold;
    cfg_setup = 0; cfg_pulse = 4; cfg_hold = 7;
    access(2'b01, 1, 0, 16'h0012, 0, 0, 0);
    ck("R4 minimal setup", n_pre, 1);
    ck("R5 long pulse", n_stb, 5);
    ck("R7 long hold", n_post, 8);
    ck("R3 address raises ale only", {s_cle, s_ale}, 2'b01);
  endtask

  task automatic t_read_gaps;
    cfg_setup = 1; cfg_pulse = 2; cfg_hold = 1; cfg_ale_gap = 5; cfg_cle_gap = 3;
    access(2'b01, 1, 0, 16'h0000, 0, 0, 0);
    access(2'b10, 0, 0, 0, 0, 0, 16'h3C40);
    ck("R8 gap after address", n_pre, 8);
    ck("R5 read uses re_n", {stb_we, stb_re}, 2'b01);
    ck("R9 no drive on read", rd_oe, 0);
    ck("R3 data raises neither", {s_cle, s_ale}, 2'b00);
    ck("R10 last strobe sample 8-bit", got_rd, 16'h0043);
    access(2'b00, 1, 0, 16'h0030, 0, 0, 0);
    access(2'b10, 0, 0, 0, 0, 0, 16'h3C50);
    ck("R8 gap after command", n_pre, 6);
    access(2'b10, 0, 0, 0, 0, 0, 16'h3C60);
    ck("R8 no gap after data", n_pre, 2);
    repeat (3) @(negedge clk);
    ck("R10 rdata held", rdata, 16'h0063);
  endtask

  task automatic t_float;
    cfg_setup = 4; cfg_pulse = 1; cfg_hold = 0; cfg_float = 3;
    access(2'b10, 1, 0, 16'h00A5, 0, 0, 0);
    ck("R9 float cycles", n_hiz, 3);
    ck("R9 write data", s_dq, 16'h00A5);
    cfg_float = 0;
  endtask

  task automatic t_wait;
    cfg_setup = 0; cfg_pulse = 1; cfg_hold = 0;
    nand_wait_n = 0;
    access(2'b10, 0, 0, 0, 6, 0, 16'h0100);
    ck("R6 stretched strobe", n_stb, 6);
    ck("R10 sample at stretched end", got_rd, 16'h0006);
    nand_wait_n = 1;
  endtask

  task automatic t_bank;
    cfg_setup = 0; cfg_pulse = 0; cfg_hold = 0;
    access(2'b00, 1, 2, 16'h00FF, 0, 0, 0);
    ck("R11 bank 2 enable during access", s_ce, 4'b1011);
    ck("R11 bank 2 stays selected", nand_ce_n, 4'b1011);
  endtask

  task automatic t_ignore;
    cfg_setup = 5; cfg_pulse = 0; cfg_hold = 0;
    access(2'b00, 1, 1, 16'h0090, 0, 2, 0);
    ck("R2 bank held during ghost", s_ce, 4'b1101);
    ck("R2 no second access", idle_after, 1);
    repeat (3) @(negedge clk);
    ck("R2 still idle", busy, 0);
    ck("R2 enable unchanged", nand_ce_n, 4'b1101);
  endtask

  task automatic t_wide;
    cfg_setup = 0; cfg_pulse = 0; cfg_hold = 0;
    cfg_wide = 0;
    access(2'b10, 1, 0, 16'hA55A, 0, 0, 0);
    ck("R12 narrow write", s_dq, 16'h005A);
    cfg_wide = 1;
    access(2'b10, 1, 0, 16'hA55A, 0, 0, 0);
    ck("R12 wide write", s_dq, 16'hA55A);
    access(2'b10, 0, 0, 0, 0, 0, 16'hBE00);
    ck("R12 wide read", got_rd, 16'hBE01);
    cfg_wide = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cmd_write;
    t_long_hold;
    t_read_gaps;
    t_float;
    t_wait;
    t_bank;
    t_ignore;
    t_wide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule